// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block decides which event a small processor core services next. A first stage routes each peripheral interrupt line to one of seven hardware-drivable general-purpose levels. A second stage merges those levels with four dedicated core events and two software-raised levels. It then picks a winner by fixed priority. Emulation, core reset, non-maskable interrupt and exception sit above the nine numbered general levels 7 to 15, and a larger number means lower priority.

Requests are held in pending latches. A nesting mask records every event whose service routine has started. A pending event is taken only when it outranks every active one, so a higher event preempts and a lower one waits. On a take, the block emits a one-cycle strobe, the event number and the index of the return-address slot that must capture the program counter. A return-from-event pulse retires the highest-priority active event, and the preempted routine below it becomes current again.

Top module: `evt_ctrl`

## Requirements
- R1: Event numbers are emulation 0, core reset 1, NMI 2, exception 3 and general levels 7 to 15. `ret_sel_o` is 0, 1, 2 or 3 for the four core events and 4 for any general level.
- R2: Among simultaneous eligible requests, the winner follows the order emulation, core reset, NMI, exception, level 7, and so on down to level 15.
- R3: The NMI request is raised by either `nmi_pin_i` or `wdog_exp_i`.
- R4: An exception arriving in the same cycle as a pending general interrupt is taken first. The general interrupt then stays blocked while the exception is active.
- R5: `swi_req_i[0]` raises level 14 and `swi_req_i[1]` raises level 15. Peripheral lines reach only levels 7 to 13.
- R6: After reset, peripheral n maps to level 7 + (n mod 7). A route write with value v in 0..6 maps line `route_idx_i` to level 7+v. A write with v = 7 is ignored.
- R7: `mask_i` bit i masks level 7+i. A masked request stays pending and is taken once its mask bit is cleared. Core events ignore the mask.
- R8: `active_o` bit 0 is emulation, bit 1 core reset, bit 2 NMI, bit 3 exception, and bit 4+k is level 7+k. A pending event is taken only if its priority is strictly higher than every active event, and taking it sets its bit.
- R9: An `rfe_i` pulse clears the highest-priority active bit. In that same cycle, a pending event may be taken against the reduced mask.
- R10: A request sampled at clock edge k gives a one-cycle `take_o` at edge k+1, with `evt_num_o` and `ret_sel_o` valid while it is high.
- R11: Reset clears all pending, active and mask state and restores the default routing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_irq_i | input | NUM_PERIPH | Peripheral interrupt lines |
| route_we_i | input | 1 | Routing table write strobe |
| route_idx_i | input | RIDX_W | Peripheral line to reroute |
| route_lvl_i | input | 3 | New level offset (level = 7 + value) |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_i | input | 9 | Mask value, bit i for level 7+i |
| emu_req_i | input | 1 | Emulation event request |
| core_rst_req_i | input | 1 | Core reset event request |
| nmi_pin_i | input | 1 | External NMI pin |
| wdog_exp_i | input | 1 | Watchdog expiry |
| exc_req_i | input | 1 | Synchronous exception request |
| swi_req_i | input | 2 | Software raise of levels 14 and 15 |
| rfe_i | input | 1 | Return-from-event pulse |
| take_o | output | 1 | Take-event strobe |
| evt_num_o | output | 4 | Number of the taken event |
| ret_sel_o | output | 3 | Return-address slot index |
| active_o | output | 13 | Nesting mask of active events |

## Verification
Two functions can meet in one cycle: a return-from-event retiring the current level, and a take of a pending level that was blocked only by that retiring level. The bench builds a nest of levels 12 and 9 and then raises level 10, which must wait. It pulses `rfe_i` and expects `take_o` for level 10 on that same edge, with the active mask holding levels 10 and 12. A second overlap, an exception and a peripheral request landing together, is judged by the exception winning and the peripheral level staying pending but blocked.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NUM_CORE  = 4;
  localparam int NUM_HWLVL = 7;
  localparam int NUM_GP    = 9;
  localparam int NPOS      = NUM_CORE + NUM_GP;
  localparam int POS_W     = $clog2(NPOS);
  localparam int EVT_W     = 4;
  localparam int SLOT_W    = 3;
  localparam int LVL_W     = 3;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_EMU = 3'd0,
    SLOT_RST = 3'd1,
    SLOT_NMI = 3'd2,
    SLOT_EXC = 3'd3,
    SLOT_IRQ = 3'd4
  } slot_e;

  // priority position to event number: core events keep their index, levels start at 7
  function automatic logic [EVT_W-1:0] pos2evt(input logic [POS_W-1:0] p);
    if (p < POS_W'(NUM_CORE)) return EVT_W'(p);
    return EVT_W'(p) + EVT_W'(3);
  endfunction

  function automatic slot_e pos2slot(input logic [POS_W-1:0] p);
    if (p < POS_W'(NUM_CORE)) return slot_e'(p[SLOT_W-1:0]);
    return SLOT_IRQ;
  endfunction
endpackage

// File: rtl/evt_prio.sv
module evt_prio #(
  parameter int W     = 13,
  parameter int IDX_W = 4
) (
  input  logic [W-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest set index is the highest priority
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/evt_route.sv
module evt_route
  import evt_pkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int RIDX_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] periph_i,
  input  logic                  wr_en_i,
  input  logic [RIDX_W-1:0]     wr_idx_i,
  input  logic [LVL_W-1:0]      wr_lvl_i,
  output logic [NUM_HWLVL-1:0]  lvl_req_o
);
  logic [LVL_W-1:0] route_q [NUM_PERIPH];
  logic [LVL_W-1:0] route_d [NUM_PERIPH];
  logic             route_en;

  assign route_en = wr_en_i && (wr_lvl_i < LVL_W'(NUM_HWLVL));

  always_comb begin
    for (int n = 0; n < NUM_PERIPH; n++) route_d[n] = route_q[n];
    route_d[wr_idx_i] = wr_lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_PERIPH; n++) route_q[n] <= LVL_W'(n % NUM_HWLVL);
    end else if (route_en) begin
      for (int n = 0; n < NUM_PERIPH; n++) route_q[n] <= route_d[n];
    end
  end

  always_comb begin
    lvl_req_o = '0;
    for (int n = 0; n < NUM_PERIPH; n++) begin
      if (periph_i[n]) lvl_req_o[route_q[n]] = 1'b1;
    end
  end
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
#(
  parameter int NUM_PERIPH = 8,
  localparam int RIDX_W    = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] periph_irq_i,
  input  logic                  route_we_i,
  input  logic [RIDX_W-1:0]     route_idx_i,
  input  logic [2:0]            route_lvl_i,
  input  logic                  mask_we_i,
  input  logic [8:0]            mask_i,
  input  logic                  emu_req_i,
  input  logic                  core_rst_req_i,
  input  logic                  nmi_pin_i,
  input  logic                  wdog_exp_i,
  input  logic                  exc_req_i,
  input  logic [1:0]            swi_req_i,
  input  logic                  rfe_i,
  output logic                  take_o,
  output logic [3:0]            evt_num_o,
  output logic [2:0]            ret_sel_o,
  output logic [12:0]           active_o
);
  logic [NUM_HWLVL-1:0] hw_lvl;
  logic [NPOS-1:0]      req_raw, pend_q, pend_d, elig, act_rem, act_q, act_d;
  logic [NPOS-1:0]      win_oh, ret_oh;
  logic [NUM_GP-1:0]    mask_q, mask_d;
  logic                 win_any, cur_any, rem_any, take_d, take_q;
  logic [POS_W-1:0]     win_idx, cur_idx, rem_idx;
  logic [EVT_W-1:0]     evt_q;
  slot_e                slot_q;

  // stage one: peripheral routing
  evt_route #(.NUM_PERIPH(NUM_PERIPH), .RIDX_W(RIDX_W)) u_route (
    .clk(clk), .rst_n(rst_n), .periph_i(periph_irq_i),
    .wr_en_i(route_we_i), .wr_idx_i(route_idx_i), .wr_lvl_i(route_lvl_i),
    .lvl_req_o(hw_lvl)
  );

  // stage two: request merge in priority-position order
  assign req_raw = {swi_req_i, hw_lvl, exc_req_i, nmi_pin_i | wdog_exp_i,
                    core_rst_req_i, emu_req_i};
  assign elig    = pend_q & ~{mask_q, {NUM_CORE{1'b0}}};

  evt_prio #(.W(NPOS), .IDX_W(POS_W)) u_win (.vec_i(elig),    .any_o(win_any), .idx_o(win_idx));
  evt_prio #(.W(NPOS), .IDX_W(POS_W)) u_cur (.vec_i(act_q),   .any_o(cur_any), .idx_o(cur_idx));
  evt_prio #(.W(NPOS), .IDX_W(POS_W)) u_rem (.vec_i(act_rem), .any_o(rem_any), .idx_o(rem_idx));

  assign ret_oh  = (rfe_i && cur_any) ? (NPOS'(1) << cur_idx) : '0;
  assign act_rem = act_q & ~ret_oh;
  assign take_d  = win_any && (!rem_any || (win_idx < rem_idx));
  assign win_oh  = take_d ? (NPOS'(1) << win_idx) : '0;

  always_comb begin
    pend_d = (pend_q & ~win_oh) | req_raw;
    act_d  = act_rem | win_oh;
    mask_d = mask_we_i ? mask_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      mask_q <= '0;
      take_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      mask_q <= mask_d;
      take_q <= take_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      slot_q <= SLOT_EMU;
    end else if (take_d) begin
      evt_q  <= pos2evt(win_idx);
      slot_q <= pos2slot(win_idx);
    end
  end

  assign take_o    = take_q;
  assign evt_num_o = evt_q;
  assign ret_sel_o = slot_q;
  assign active_o  = act_q;
endmodule

// File: rtl/evt_ctrl_chk.sv
module evt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rfe_i,
  input logic        take_o,
  input logic [3:0]  evt_num_o,
  input logic [2:0]  ret_sel_o,
  input logic [12:0] active_o
);
  function automatic logic [3:0] e2p(input logic [3:0] e);
    return (e < 4'd4) ? e : e - 4'd3;
  endfunction

  function automatic logic [12:0] upto(input logic [3:0] p);
    logic [12:0] m;
    for (int i = 0; i < 13; i++) m[i] = (4'(i) <= p);
    return m;
  endfunction

  // R1
  slot_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((evt_num_o < 4'd4) ? (ret_sel_o == evt_num_o[2:0]) : (ret_sel_o == 3'd4)));

  // R1
  evt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !(evt_num_o inside {4'd4, 4'd5, 4'd6}));

  // R8
  taken_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> active_o[e2p(evt_num_o)]);

  // R8
  strict_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !$past(rfe_i)) |-> (($past(active_o) & upto(e2p(evt_num_o))) == 13'd0));

  // R9
  rfe_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rfe_i) && !take_o && ($past(active_o) != 13'd0))
      |-> ($countones(active_o) == $countones($past(active_o)) - 1));

  // R10
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_o && !$past(rfe_i)) |-> $stable(active_o));
endmodule

bind evt_ctrl evt_ctrl_chk u_evt_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .rfe_i(rfe_i), .take_o(take_o),
  .evt_num_o(evt_num_o), .ret_sel_o(ret_sel_o), .active_o(active_o)
);

// File: tb/test_evt_ctrl.sv
module test_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  periph;
  logic        route_we, mask_we, rfe;
  logic [2:0]  route_idx, route_lvl;
  logic [8:0]  mask;
  logic [4:0]  core;   // {emu, core_rst, nmi_pin, wdog, exc}
  logic [1:0]  swi;
  logic        take;
  logic [3:0]  evt;
  logic [2:0]  slot;
  logic [12:0] act;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  evt_ctrl #(.NUM_PERIPH(8)) i_evt_ctrl (
    .clk(clk), .rst_n(rst_n), .periph_irq_i(periph),
    .route_we_i(route_we), .route_idx_i(route_idx), .route_lvl_i(route_lvl),
    .mask_we_i(mask_we), .mask_i(mask),
    .emu_req_i(core[4]), .core_rst_req_i(core[3]), .nmi_pin_i(core[2]),
    .wdog_exp_i(core[1]), .exc_req_i(core[0]), .swi_req_i(swi), .rfe_i(rfe),
    .take_o(take), .evt_num_o(evt), .ret_sel_o(slot), .active_o(act)
  );

  // {periph, swi, core, expected evt, expected slot}
  localparam logic [21:0] VEC [13] = '{
    {8'h01, 2'b00, 5'b00000, 4'd7,  3'd4},
    {8'h40, 2'b00, 5'b00000, 4'd13, 3'd4},
    {8'h80, 2'b00, 5'b00000, 4'd7,  3'd4},
    {8'h30, 2'b00, 5'b00000, 4'd11, 3'd4},
    {8'h00, 2'b01, 5'b00000, 4'd14, 3'd4},
    {8'h00, 2'b10, 5'b00000, 4'd15, 3'd4},
    {8'h00, 2'b11, 5'b00000, 4'd14, 3'd4},
    {8'h01, 2'b00, 5'b00001, 4'd3,  3'd3},
    {8'h00, 2'b00, 5'b00010, 4'd2,  3'd2},
    {8'h00, 2'b00, 5'b00100, 4'd2,  3'd2},
    {8'hFF, 2'b11, 5'b11111, 4'd0,  3'd0},
    {8'h00, 2'b00, 5'b01100, 4'd1,  3'd1},
    {8'h04, 2'b01, 5'b00000, 4'd9,  3'd4}
  };

  task automatic chk(input string req, input logic [31:0] actv, input logic [31:0] expv);
    checks++;
    if (actv !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, actv, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive one cycle at a negedge, leave at the negedge after the take edge
  task automatic apply(input logic [7:0] p, input logic [1:0] s, input logic [4:0] c);
    periph = p; swi = s; core = c;
    @(negedge clk);
    periph = '0; swi = '0; core = '0;
    @(negedge clk);
  endtask

  task automatic pulse_rfe();
    rfe = 1'b1;
    @(negedge clk);
    rfe = 1'b0;
  endtask

  task automatic wr_mask(input logic [8:0] m);
    mask_we = 1'b1; mask = m;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic wr_route(input logic [2:0] idx, input logic [2:0] lvl);
    route_we = 1'b1; route_idx = idx; route_lvl = lvl;
    @(negedge clk);
    route_we = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; periph = '0; route_we = 1'b0; mask_we = 1'b0; rfe = 1'b0;
    route_idx = '0; route_lvl = '0; mask = '0; core = '0; swi = '0;
    @(negedge clk);
    do_reset();
    // R11 reset state
    chk("R11 take", 32'(take), 0);
    chk("R11 active", 32'(act), 0);

    // R2 R1 R3 R4 R5 R6 vector table
    for (int v = 0; v < 13; v++) begin
      do_reset();
      apply(VEC[v][21:14], VEC[v][13:12], VEC[v][11:7]);
      chk($sformatf("R10 take vec %0d", v), 32'(take), 1);
      chk($sformatf("R2 evt vec %0d", v), 32'(evt), 32'(VEC[v][6:3]));
      chk($sformatf("R1 slot vec %0d", v), 32'(slot), 32'(VEC[v][2:0]));
    end
    // R10 strobe lasts one cycle
    @(negedge clk);
    chk("R10 single pulse", 32'(take), 0);

    // R4 exception blocks the peripheral level pending with it
    do_reset();
    apply(8'h01, 2'b00, 5'b00001);
    @(negedge clk);
    chk("R4 level7 blocked", 32'(take), 0);
    chk("R4 active exc only", 32'(act), 32'h008);

    // R8 R9 nesting and same-cycle retire plus take
    do_reset();
    apply(8'h20, 2'b00, 5'b0);          // level 12
    chk("R8 take 12", 32'(evt), 12);
    apply(8'h04, 2'b00, 5'b0);          // level 9 preempts
    chk("R8 preempt take", 32'(take), 1);
    chk("R8 preempt evt", 32'(evt), 9);
    chk("R8 nest mask", 32'(act), 32'h240);
    apply(8'h08, 2'b00, 5'b0);          // level 10 must wait
    chk("R8 lower waits", 32'(take), 0);
    @(negedge clk);
    chk("R8 still waiting", 32'(take), 0);
    pulse_rfe();
    chk("R9 take on rfe", 32'(take), 1);
    chk("R9 evt on rfe", 32'(evt), 10);
    chk("R9 mask on rfe", 32'(act), 32'h280);
    pulse_rfe();
    chk("R9 retire 10", 32'(act), 32'h200);
    chk("R9 no take", 32'(take), 0);
    pulse_rfe();
    chk("R9 retire 12", 32'(act), 0);

    // R8 exception nests over a level
    do_reset();
    apply(8'h01, 2'b00, 5'b0);
    apply(8'h00, 2'b00, 5'b00001);
    chk("R8 exc over level", 32'(evt), 3);
    chk("R8 exc nest mask", 32'(act), 32'h018);

    // R11 reset mid-service clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 active cleared", 32'(act), 0);
    chk("R11 no take", 32'(take), 0);

    // R7 mask holds request pending, release takes it
    do_reset();
    wr_mask(9'b000000010);
    apply(8'h02, 2'b00, 5'b0);
    chk("R7 masked no take", 32'(take), 0);
    wr_mask(9'b0);
    @(negedge clk);
    chk("R7 release take", 32'(take), 1);
    chk("R7 release evt", 32'(evt), 8);

    // R7 R3 core events ignore mask
    do_reset();
    wr_mask(9'h1FF);
    apply(8'h01, 2'b00, 5'b00010);
    chk("R7 nmi unmasked", 32'(evt), 2);
    chk("R3 nmi take", 32'(take), 1);
    pulse_rfe();
    chk("R7 masked stays off", 32'(take), 0);
    chk("R7 active empty", 32'(act), 0);

    // R6 route rewrite and ignored value 7
    do_reset();
    wr_route(3'd0, 3'd6);
    apply(8'h01, 2'b00, 5'b0);
    chk("R6 rerouted", 32'(evt), 13);
    do_reset();
    wr_route(3'd1, 3'd7);
    apply(8'h02, 2'b00, 5'b0);
    chk("R6 value 7 ignored", 32'(evt), 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule